// File: doc/BRIEF.md
# Dual-Enable Byte-Lane SRAM Bank

This block is a clocked behavioural model of the small static RAM that sits beside a flash array inside a combined memory part. The host drives asynchronous pin-level strobes: two SRAM enables of opposite polarity, a flash enable, a write strobe, an output enable and two active-low byte selects. The block samples all of them on its own clock through a two-stage synchroniser. Reads are registered onto a 16-bit bus, with a drive-enable flag standing in for the tri-state buffer. Writes are committed at the moment the write condition ends.

A configuration pin picks the organisation. In the word organisation each address names a 16-bit word, and the byte selects pick the lanes. In the byte organisation the address counts bytes, bit 0 picks the lane, and data travels on the low byte of the bus. The SRAM covers only the lowest addresses of the device map. Its depth is a parameter, so simulation can use a small array.

Top module: `sram_combo_bank`

## Requirements
- R1: While reset is held and on the first clock after it, dout_en is 0 and dout is 0.
- R2: The bank is selected only when ce_lo_n is 0, ce_hi is 1 and flash_en_n is 1. A read with ce_lo_n high or ce_hi low gives no drive (dout_en stays 0).
- R3: When oe_n is high, dout_en is 0 from the third rising clock edge after oe_n is sampled high.
- R4: A write is active while the bank is selected, the address is in range and we_n is 0. It commits once, when that condition ends. The end may come from we_n rising, from ce_lo_n rising or from ce_hi falling.
- R5: The committed address and data are the values sampled in the last cycle the write was active. Data that changes together with the terminating strobe is not stored.
- R6: With flash_en_n low (flash selected), no SRAM read drives and no SRAM write changes the array.
- R7: With wide_mode=1, a write updates only the lanes whose select is low: lb_n picks bits 7:0 and ub_n picks bits 15:8.
- R8: With wide_mode=1, a read returns zero in any lane whose select is high.
- R9: With wide_mode=0, the address counts bytes. addr[0]=0 picks the lower lane and addr[0]=1 picks the upper lane of word addr>>1. Write data is taken from din[7:0]. Read data appears on dout[7:0] with dout[15:8]=0. ub_n and lb_n are ignored.
- R10: The bank occupies only the lowest addresses. In word mode this is addresses below 2^WORD_AW, and in byte mode addresses below 2^(WORD_AW+1). An address outside the range gives no drive, and a write to it leaves the array unchanged.
- R11: For a read, dout_en rises on the third rising clock edge after the read condition is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_lo_n | input | 1 | Active-low SRAM enable |
| ce_hi | input | 1 | Active-high SRAM enable |
| flash_en_n | input | 1 | Active-low flash enable; must be high for SRAM access |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| ub_n | input | 1 | Active-low upper byte select (bits 15:8) |
| lb_n | input | 1 | Active-low lower byte select (bits 7:0) |
| wide_mode | input | 1 | 1 = 16-bit words, 0 = bytes |
| addr | input | ADDR_W | Device address |
| din | input | 16 | Write data |
| dout | output | 16 | Registered read data |
| dout_en | output | 1 | Bus drive enable (0 = high impedance) |

## Verification
The write-tracking flag may stick or fail to clear. That shows up as a missing or wrong stored value on the next read-back of the targeted word, a few tens of cycles after the write ends. Wrong captured address or data gives the same symptom at a neighbouring word or lane. An error in the select decode or the range check shows at dout_en three edges after the read strobe. A lane-mask error shows in the zeroed or merged bytes of the very next read.

// File: rtl/sram_combo_pkg.sv
package sram_combo_pkg;

    // Sampled control pins, carried as one bundle through the synchroniser.
    typedef struct packed {
        logic ce_lo_n;
        logic ce_hi;
        logic flash_n;
        logic we_n;
        logic oe_n;
        logic ub_n;
        logic lb_n;
        logic wide;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Idle pin levels: bank deselected, strobes inactive.
    localparam ctl_t CTL_IDLE = '{ce_lo_n: 1'b1, ce_hi: 1'b0, flash_n: 1'b1,
                                  we_n: 1'b1, oe_n: 1'b1, ub_n: 1'b1,
                                  lb_n: 1'b1, wide: 1'b1};

    // Lane enables: bit 1 = upper byte, bit 0 = lower byte.
    function automatic logic [1:0] lane_sel(input logic wide, input logic ub_n,
                                            input logic lb_n, input logic a0);
        if (wide) return {~ub_n, ~lb_n};
        return a0 ? 2'b10 : 2'b01;
    endfunction

    // In byte mode the single byte is replicated onto both lanes.
    function automatic logic [15:0] wr_fmt(input logic wide, input logic [15:0] d);
        return wide ? d : {d[7:0], d[7:0]};
    endfunction

    // Format a stored word onto the bus according to the organisation.
    function automatic logic [15:0] rd_fmt(input logic wide, input logic [1:0] lanes,
                                           input logic [15:0] w);
        if (wide) return w & {{8{lanes[1]}}, {8{lanes[0]}}};
        return {8'h00, lanes[1] ? w[15:8] : w[7:0]};
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   IDLE    = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= IDLE;
            synced <= IDLE;
        end else begin
            stage1 <= raw;
            synced <= stage1;
        end
    end
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
    import sram_combo_pkg::*;
#(
    parameter int WORD_AW = 6,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  ctl_t               ctl,
    input  logic [ADDR_W-1:0]  a,
    input  logic [15:0]        d,
    output logic               wr_en,
    output logic [WORD_AW-1:0] wr_idx,
    output logic [15:0]        wr_data,
    output logic [1:0]         wr_lanes,
    output logic               rd_act,
    output logic [WORD_AW-1:0] rd_idx,
    output logic [1:0]         rd_lanes
);
    logic               sel, in_range, wr_live, armed;
    logic [WORD_AW-1:0] idx;
    logic [1:0]         lanes;

    always_comb begin
        sel      = !ctl.ce_lo_n && ctl.ce_hi && ctl.flash_n;
        in_range = ctl.wide ? (a[ADDR_W-1:WORD_AW] == '0)
                            : (a[ADDR_W-1:WORD_AW+1] == '0);
        idx      = ctl.wide ? a[WORD_AW-1:0] : a[WORD_AW:1];
        lanes    = lane_sel(ctl.wide, ctl.ub_n, ctl.lb_n, a[0]);
        wr_live  = sel && in_range && !ctl.we_n;
        rd_act   = sel && in_range && ctl.we_n && !ctl.oe_n;
        rd_idx   = idx;
        rd_lanes = lanes;
        wr_en    = armed && !wr_live;
    end

    // Capture while the write is live; commit on the cycle it ends.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            wr_lanes <= '0;
        end else begin
            armed <= wr_live;
            if (wr_live) begin
                wr_idx   <= idx;
                wr_data  <= wr_fmt(ctl.wide, d);
                wr_lanes <= lanes;
            end
        end
    end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int WORD_AW = 6,
    parameter int LANES   = 2
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [WORD_AW-1:0] wr_idx,
    input  logic [LANES*8-1:0] wr_data,
    input  logic [LANES-1:0]   wr_lanes,
    input  logic [WORD_AW-1:0] rd_idx,
    output logic [LANES*8-1:0] rd_word
);
    localparam int DEPTH = 1 << WORD_AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g])
                cells[wr_idx] <= wr_data[g*8 +: 8];
        end

        assign rd_word[g*8 +: 8] = cells[rd_idx];
    end
endmodule

// File: rtl/sram_combo_bank.sv
module sram_combo_bank
    import sram_combo_pkg::*;
#(
    parameter int WORD_AW = 6,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_lo_n,
    input  logic              ce_hi,
    input  logic              flash_en_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic              dout_en
);
    localparam int BUS_W = ADDR_W + 16;

    ctl_t               ctl_raw, ctl_s;
    logic [BUS_W-1:0]   bus_s;
    logic               wr_en, rd_act;
    logic [WORD_AW-1:0] wr_idx, rd_idx;
    logic [15:0]        wr_data, rd_word;
    logic [1:0]         wr_lanes, rd_lanes;

    assign ctl_raw = '{ce_lo_n: ce_lo_n, ce_hi: ce_hi, flash_n: flash_en_n,
                       we_n: we_n, oe_n: oe_n, ub_n: ub_n, lb_n: lb_n,
                       wide: wide_mode};

    pin_sync #(.W(CTL_W), .IDLE(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst(rst), .raw(ctl_raw), .synced(ctl_s)
    );

    // Address and data follow the same two stages so they stay aligned.
    pin_sync #(.W(BUS_W), .IDLE('0)) u_bus_sync (
        .clk(clk), .rst(rst), .raw({addr, din}), .synced(bus_s)
    );

    sram_access_ctrl #(.WORD_AW(WORD_AW), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .ctl(ctl_s),
        .a(bus_s[BUS_W-1:16]), .d(bus_s[15:0]),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_lanes(wr_lanes),
        .rd_act(rd_act), .rd_idx(rd_idx), .rd_lanes(rd_lanes)
    );

    sram_lane_array #(.WORD_AW(WORD_AW), .LANES(2)) u_array (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_lanes(wr_lanes), .rd_idx(rd_idx), .rd_word(rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_en <= 1'b0;
            dout    <= '0;
        end else begin
            dout_en <= rd_act;
            dout    <= rd_act ? rd_fmt(ctl_s.wide, rd_lanes, rd_word) : '0;
        end
    end
endmodule

// File: rtl/sram_combo_chk.sv
module sram_combo_chk (
    input logic        clk,
    input logic        rst,
    input logic        ce_lo_n,
    input logic        flash_en_n,
    input logic        oe_n,
    input logic        wide_mode,
    input logic [15:0] dout,
    input logic        dout_en
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!dout_en && dout == 16'h0000));

    // R2
    deselect_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ce_lo_n, 3) |-> !dout_en);

    // R3
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(oe_n, 3) |-> !dout_en);

    // R6
    flash_owner_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(flash_en_n, 3) |-> !dout_en);

    // R9
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wide_mode, 3) |-> dout[15:8] == 8'h00);
endmodule

bind sram_combo_bank sram_combo_chk u_sram_combo_chk (
    .clk(clk), .rst(rst), .ce_lo_n(ce_lo_n), .flash_en_n(flash_en_n),
    .oe_n(oe_n), .wide_mode(wide_mode), .dout(dout), .dout_en(dout_en)
);

// File: tb/test_sram_combo_bank.sv
module test_sram_combo_bank;
    localparam int WORD_AW = 6;
    localparam int ADDR_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_lo_n = 1'b1, ce_hi = 1'b0, flash_en_n = 1'b1;
    logic              we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic              wide_mode = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       din = '0;
    logic [15:0]       dout;
    logic              dout_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sram_combo_bank #(.WORD_AW(WORD_AW), .ADDR_W(ADDR_W)) i_sram_combo_bank (
        .clk(clk), .rst(rst), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi),
        .flash_en_n(flash_en_n), .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n),
        .lb_n(lb_n), .wide_mode(wide_mode), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        ce_lo_n = 1'b1; ce_hi = 1'b0; flash_en_n = 1'b1;
        we_n = 1'b1; oe_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1;
    endtask

    // term: 0 we_n rises, 1 ce_lo_n rises, 2 ce_hi falls, 3 we_n rises with new din
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                      input logic u, input logic l, input logic wide,
                      input int term, input logic fl);
        @(negedge clk);
        addr = a; din = d; ub_n = u; lb_n = l; wide_mode = wide;
        flash_en_n = fl; ce_lo_n = 1'b0; ce_hi = 1'b1; we_n = 1'b0; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        case (term)
            1: ce_lo_n = 1'b1;
            2: ce_hi = 1'b0;
            3: begin we_n = 1'b1; din = ~d; end
            default: we_n = 1'b1;
        endcase
        repeat (3) @(negedge clk);
        idle();
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic u, input logic l,
                      input logic wide, input logic fl, input logic cel,
                      input logic ceh, output logic [15:0] data, output logic en);
        @(negedge clk);
        addr = a; ub_n = u; lb_n = l; wide_mode = wide; flash_en_n = fl;
        ce_lo_n = cel; ce_hi = ceh; we_n = 1'b1; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        data = dout; en = dout_en;
        idle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 dout_en", {15'h0, dout_en}, 16'h0000);
        chk("R1 dout", dout, 16'h0000);
    endtask

    task automatic t_lanes();
        logic [15:0] v; logic e;
        wr(8'd3, 16'hA5C3, 1'b0, 1'b0, 1'b1, 0, 1'b1);
        rd(8'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R4 we_n end commit", v, 16'hA5C3);
        chk("R2 selected read drives", {15'h0, e}, 16'h0001);
        rd(8'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R8 upper only", v, 16'hA500);
        rd(8'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R8 lower only", v, 16'h00C3);
        wr(8'd3, 16'h1234, 1'b1, 1'b0, 1'b1, 0, 1'b1);
        rd(8'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R7 lower lane write", v, 16'hA534);
        wr(8'd3, 16'h9900, 1'b0, 1'b1, 1'b1, 0, 1'b1);
        rd(8'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R7 upper lane write", v, 16'h9934);
    endtask

    task automatic t_terms();
        logic [15:0] v; logic e;
        wr(8'd5, 16'h1111, 1'b0, 1'b0, 1'b1, 1, 1'b1);
        rd(8'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R4 ce_lo_n end commit", v, 16'h1111);
        wr(8'd6, 16'h2222, 1'b0, 1'b0, 1'b1, 2, 1'b1);
        rd(8'd6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R4 ce_hi end commit", v, 16'h2222);
    endtask

    task automatic t_late_data();
        logic [15:0] v; logic e;
        wr(8'd7, 16'h3333, 1'b0, 1'b0, 1'b1, 3, 1'b1);
        rd(8'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R5 data held before end", v, 16'h3333);
    endtask

    task automatic t_standby();
        logic [15:0] v; logic e;
        wr(8'd7, 16'h5555, 1'b0, 1'b0, 1'b1, 0, 1'b0);
        rd(8'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R6 write ignored", v, 16'h3333);
        rd(8'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, v, e);
        chk("R6 no drive flash", {15'h0, e}, 16'h0000);
        rd(8'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, v, e);
        chk("R2 ce_hi low no drive", {15'h0, e}, 16'h0000);
        rd(8'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, v, e);
        chk("R2 ce_lo_n high no drive", {15'h0, e}, 16'h0000);
    endtask

    task automatic t_oe_timing();
        @(negedge clk);
        addr = 8'd5; wide_mode = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
        ce_lo_n = 1'b0; ce_hi = 1'b1; flash_en_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 not before third edge", {15'h0, dout_en}, 16'h0000);
        @(negedge clk);
        chk("R11 on third edge", {15'h0, dout_en}, 16'h0001);
        chk("R11 data", dout, 16'h1111);
        oe_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 still driving before third edge", {15'h0, dout_en}, 16'h0001);
        @(negedge clk);
        chk("R3 released", {15'h0, dout_en}, 16'h0000);
        idle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_bytes();
        logic [15:0] v; logic e;
        wr(8'd20, 16'hFF5A, 1'b1, 1'b1, 1'b0, 0, 1'b1);
        wr(8'd21, 16'hEEC6, 1'b1, 1'b1, 1'b0, 0, 1'b1);
        rd(8'd20, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, v, e);
        chk("R9 byte lower", v, 16'h005A);
        rd(8'd21, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, v, e);
        chk("R9 byte upper", v, 16'h00C6);
        rd(8'd10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R9 merged word", v, 16'hC65A);
    endtask

    task automatic t_range();
        logic [15:0] v; logic e;
        wr(8'd0, 16'h0F0F, 1'b0, 1'b0, 1'b1, 0, 1'b1);
        wr(8'd64, 16'h7777, 1'b0, 1'b0, 1'b1, 0, 1'b1);
        wr(8'd128, 16'h0088, 1'b0, 1'b0, 1'b0, 0, 1'b1);
        rd(8'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R10 out of range write ignored", v, 16'h0F0F);
        rd(8'd64, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, v, e);
        chk("R10 word out of range no drive", {15'h0, e}, 16'h0000);
        rd(8'd128, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, v, e);
        chk("R10 byte out of range no drive", {15'h0, e}, 16'h0000);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lanes();
        t_terms();
        t_late_data();
        t_standby();
        t_oe_timing();
        t_bytes();
        t_range();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule